// File: doc/BRIEF.md
# Serial Byte Memory Command Decoder

This block sits behind a serial receiver and turns the bytes it hands over into single-byte memory accesses. Each received byte arrives with a one-cycle valid strobe. The block assembles a framed command from these bytes. It then raises one request on a simple request/acknowledge memory port. For a read, it returns the fetched byte on a transmit port that uses a valid/ready handshake.

Framing depends on bit 7 of each byte. Only a command's opening byte has bit 7 set, so any byte with bit 7 set starts a fresh frame, even in the middle of another one. The block also drives the address of the most recent completed command to neighbouring logic, which uses that address for its own periodic tests.

While a request or a reply byte is outstanding, the block ignores every incoming byte, so only one access is in flight at a time.

Top module: `serial_cmd_decoder`

## Requirements
- R1: While `rst_n` is sampled low, and right after it rises, `mem_req` and `tx_valid` are 0 and `cmd_addr` is 0.
- R2: An opening byte has bit 7 = 1 and bit 6 = 0. Bit 5 selects the access type (1 = read, 0 = write) and bits 4..0 are address bits 25..21. `mem_wr` shows the type of the issued request, with 1 meaning write.
- R3: The opening byte is followed by three address bytes with bit 7 = 0. Their bits 6..0 supply address bits 20..14, 13..7 and 6..0, in that order, which gives the 26-bit `mem_addr`.
- R4: A read frame completes with its third address byte. `mem_req` is high in the cycle after the edge that samples that byte, with `mem_wr` = 0.
- R5: A write frame takes a fourth payload byte after the address bytes. That byte appears on `mem_wdata` with `mem_req` high and `mem_wr` = 1 in the next cycle. A write produces no transmit byte.
- R6: In the cycle after an acknowledged read, `tx_valid` is high and `tx_byte` equals the `mem_rdata` sampled with the acknowledge. Both hold until `tx_ready` is sampled high.
- R7: A byte with bit 7 = 1 that arrives part-way through a frame discards the partial frame and is decoded as a new opening byte.
- R8: A byte with bit 7 = 0 that arrives when no frame is open is ignored and issues no request.
- R9: A byte with bits 7..6 = 11 is rejected. It closes any open frame, and the address bytes that follow it issue no request.
- R10: While `mem_req` or `tx_valid` is high, received bytes are ignored, including opening bytes.
- R11: `cmd_addr` takes the full address of each completed frame on the edge that completes it and keeps that value otherwise.
- R12: `mem_req`, `mem_wr`, `mem_addr` and `mem_wdata` stay unchanged until `mem_ack` is sampled high. `mem_req` drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 26 | Byte address of the request |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 8 | Read data |
| tx_valid | output | 1 | Reply byte available |
| tx_byte | output | 8 | Reply byte (read result) |
| tx_ready | input | 1 | Transmitter accepts the reply byte |
| cmd_addr | output | 26 | Address of the last completed command |

## Verification
Most internal faults show up at the ports within one frame.

- A wrong position counter makes the next request carry a shifted address, or makes a write request appear one byte early, in the very cycle after the faulty byte.
- A lost pending flag lets bytes through while busy. A second request then follows the acknowledge by a few cycles.
- A wrong open-frame state turns stray low bytes or rejected openers into spurious requests.

The reference model in the bench follows the frame state byte by byte. Any such divergence is therefore reported in the cycle where the outputs first disagree, not at the end of the run.

// File: rtl/sercmd_pkg.sv
// Shared definitions for the serial memory command decoder.
// Assumes byte-wide serial data; the frame layout constants live here.
package sercmd_pkg;
    localparam int BYTE_W   = 8;
    localparam int MARK_BIT = 7;  // set only on opening bytes
    localparam int RSVD_BIT = 6;  // must be zero on a valid opener
    localparam int RD_BIT   = 5;  // 1 = read request

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_ADDR = 2'd1,
        FR_DATA = 2'd2
    } frame_st_t;
endpackage

// File: rtl/frame_assembler.sv
// Collects received bytes into a command frame and fires a one-cycle
// launch when the frame completes. Assumes the caller blocks it while a
// previous command is in flight; blocked bytes are dropped entirely.
module frame_assembler
    import sercmd_pkg::*;
#(
    parameter int HDR_ADDR_BITS = 5,
    parameter int ADDR_BYTES    = 3,
    parameter int PAY_BITS      = 7,
    parameter int ADDR_W        = HDR_ADDR_BITS + ADDR_BYTES * PAY_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blocked,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              launch,
    output logic              launch_rd,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [BYTE_W-1:0] launch_data
);
    localparam int LO_W  = ADDR_BYTES * PAY_BITS;
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    frame_st_t                st_q;
    logic [CNT_W-1:0]         cnt_q;
    logic                     rd_q;
    logic [HDR_ADDR_BITS-1:0] hi_q;
    logic [LO_W-1:0]          lo_q;

    logic            take;
    logic            is_hdr;
    logic            hdr_ok;
    logic            last_addr;
    logic [LO_W-1:0] lo_next;

    // Purpose: classify the incoming byte and decide whether a frame ends now.
    always_comb begin
        take      = rx_valid && !blocked;
        is_hdr    = rx_byte[MARK_BIT];
        hdr_ok    = is_hdr && !rx_byte[RSVD_BIT];
        last_addr = (cnt_q == LAST_IDX);
        lo_next   = {lo_q[LO_W-PAY_BITS-1:0], rx_byte[PAY_BITS-1:0]};
        launch    = take && !is_hdr &&
                    (((st_q == FR_ADDR) && last_addr && rd_q) || (st_q == FR_DATA));
        launch_rd   = rd_q;
        launch_addr = {hi_q, ((st_q == FR_DATA) ? lo_q : lo_next)};
        launch_data = rx_byte;
    end

    // Purpose: advance the frame state on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FR_IDLE;
            cnt_q <= '0;
            rd_q  <= 1'b0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else if (take) begin
            if (is_hdr) begin
                if (hdr_ok) begin
                    st_q  <= FR_ADDR;
                    cnt_q <= '0;
                    rd_q  <= rx_byte[RD_BIT];
                    hi_q  <= rx_byte[HDR_ADDR_BITS-1:0];
                end else begin
                    st_q <= FR_IDLE;
                end
            end else begin
                case (st_q)
                    FR_ADDR: begin
                        lo_q <= lo_next;
                        if (last_addr) begin
                            st_q <= rd_q ? FR_IDLE : FR_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FR_DATA: st_q <= FR_IDLE;
                    default: st_q <= FR_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mem_req_port.sv
// Holds one memory request from launch until acknowledge and flags a
// read completion for the reply path. Assumes launch never arrives while
// a request is already pending (the top blocks the assembler).
module mem_req_port
    import sercmd_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              launch_rd,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [BYTE_W-1:0] launch_data,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_data
);
    // Purpose: raise and hold the request, clearing it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_wr    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (mem_req && mem_ack) begin
            mem_req <= 1'b0;
        end else if (launch) begin
            mem_req  <= 1'b1;
            mem_wr   <= !launch_rd;
            mem_addr <= launch_addr;
            if (!launch_rd) begin
                mem_wdata <= launch_data;
            end
        end
    end

    // Purpose: mark the acknowledge cycle of a read for the reply path.
    always_comb begin
        rsp_valid = mem_req && mem_ack && !mem_wr;
        rsp_data  = mem_rdata;
    end
endmodule

// File: rtl/reply_sender.sv
// Presents a read result to the transmitter and holds it until taken.
// Assumes a new result only arrives when no byte is waiting.
module reply_sender
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    input  logic [BYTE_W-1:0] rsp_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);
    // Purpose: load a reply byte and release it on the ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end else if (rsp_valid) begin
            tx_valid <= 1'b1;
            tx_byte  <= rsp_data;
        end
    end
endmodule

// File: rtl/serial_cmd_decoder.sv
// Top of the serial memory command decoder: frame assembly, request
// holding and reply delivery. Assumes one byte at most per cycle and that
// bytes arriving while a command is in flight may be lost.
module serial_cmd_decoder
    import sercmd_pkg::*;
#(
    parameter int HDR_ADDR_BITS = 5,
    parameter int ADDR_BYTES    = 3,
    parameter int PAY_BITS      = 7,
    parameter int ADDR_W        = HDR_ADDR_BITS + ADDR_BYTES * PAY_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] cmd_addr
);
    logic              blocked;
    logic              launch;
    logic              launch_rd;
    logic [ADDR_W-1:0] launch_addr;
    logic [BYTE_W-1:0] launch_data;
    logic              rsp_valid;
    logic [BYTE_W-1:0] rsp_data;

    // Purpose: stall frame intake while a request or reply is outstanding.
    always_comb begin
        blocked  = mem_req || tx_valid;
        cmd_addr = mem_addr;
    end

    frame_assembler #(
        .HDR_ADDR_BITS(HDR_ADDR_BITS),
        .ADDR_BYTES   (ADDR_BYTES),
        .PAY_BITS     (PAY_BITS),
        .ADDR_W       (ADDR_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .blocked    (blocked),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .launch     (launch),
        .launch_rd  (launch_rd),
        .launch_addr(launch_addr),
        .launch_data(launch_data)
    );

    mem_req_port #(
        .ADDR_W(ADDR_W)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_rd  (launch_rd),
        .launch_addr(launch_addr),
        .launch_data(launch_data),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    reply_sender u_reply (
        .clk      (clk),
        .rst_n    (rst_n),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );
endmodule

// File: rtl/serial_cmd_decoder_chk.sv
// Port-level protocol checks for the serial memory command decoder,
// bound to every instance of the top module.
module serial_cmd_decoder_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_ack,
    input logic [7:0]        mem_rdata,
    input logic              tx_valid,
    input logic [7:0]        tx_byte,
    input logic              tx_ready,
    input logic [ADDR_W-1:0] cmd_addr
);
    assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wr) && $stable(mem_wdata));

    assert_req_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);

    assert_tx_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

    assert_read_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_wr |=> tx_valid && (tx_byte == $past(mem_rdata)));

    assert_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_wr |=> !tx_valid);

    assert_single_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && tx_valid));

    assert_busy_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || tx_valid) |=> $stable(cmd_addr));

    assert_addr_moves_with_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |=> $stable(cmd_addr) || mem_req);
endmodule

bind serial_cmd_decoder serial_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .tx_ready (tx_ready),
    .cmd_addr (cmd_addr)
);

// File: tb/sim_serial_cmd_decoder.sv
`timescale 1ns/1ps
module sim_serial_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        mem_req;
    logic        mem_wr;
    logic [25:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b1;
    logic [25:0] cmd_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    bit cmp_en = 0;

    always #10 clk = ~clk;

    serial_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_ready(tx_ready), .cmd_addr(cmd_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // ---------------- bench memory and transmitter ----------------
    logic [7:0] store [int];
    int ack_delay = 2;
    int ack_cnt = 0;
    int rdy_mode = 0;      // 0 always ready, 1 pseudo-random, 2 never
    logic [31:0] lfsr = 32'h1ACE_B00C;

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    always @(negedge clk) begin
        lfsr = step(lfsr);
        if (!rst_n) begin
            mem_ack = 1'b0;
            ack_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            ack_cnt = 0;
        end else if (mem_req) begin
            if (ack_cnt >= ack_delay) begin
                mem_ack = 1'b1;
                if (mem_wr) store[int'(mem_addr)] = mem_wdata;
                mem_rdata = store.exists(int'(mem_addr)) ? store[int'(mem_addr)]
                                                         : (mem_addr[7:0] ^ 8'hA5);
            end else begin
                ack_cnt++;
            end
        end
        case (rdy_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = lfsr[3];
            default: tx_ready = 1'b0;
        endcase
    end

    // ---------------- reference model ----------------
    bit         m_req, m_wr, m_txv, m_rd;
    logic [7:0] m_wdata, m_txb;
    logic [25:0] m_addr;
    int         m_ph;
    logic [31:0] m_acc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_req = 0; m_wr = 0; m_txv = 0; m_rd = 0; m_ph = 0;
            m_wdata = 0; m_txb = 0; m_addr = 0; m_acc = 0;
        end else if (m_req) begin
            if (mem_ack) begin
                m_req = 0;
                if (!m_wr) begin m_txv = 1; m_txb = mem_rdata; end
            end
        end else if (m_txv) begin
            if (tx_ready) m_txv = 0;
        end else if (rx_valid) begin
            if (rx_byte[7]) begin
                if (!rx_byte[6]) begin
                    m_ph = 1; m_rd = rx_byte[5]; m_acc = {27'd0, rx_byte[4:0]};
                end else begin
                    m_ph = 0;
                end
            end else if (m_ph >= 1 && m_ph <= 3) begin
                m_acc = (m_acc << 7) | {25'd0, rx_byte[6:0]};
                if (m_ph == 3) begin
                    if (m_rd) begin
                        m_req = 1; m_wr = 0; m_addr = m_acc[25:0]; m_ph = 0;
                    end else begin
                        m_ph = 4;
                    end
                end else begin
                    m_ph++;
                end
            end else if (m_ph == 4) begin
                m_req = 1; m_wr = 1; m_addr = m_acc[25:0]; m_wdata = rx_byte; m_ph = 0;
            end
        end
        cmp_en = 1;
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            chk("R4 mem_req", {31'd0, mem_req}, {31'd0, m_req});
            chk("R11 cmd_addr", {6'd0, cmd_addr}, {6'd0, m_addr});
            chk("R6 tx_valid", {31'd0, tx_valid}, {31'd0, m_txv});
            if (m_req) begin
                chk("R2 mem_wr", {31'd0, mem_wr}, {31'd0, m_wr});
                chk("R3 mem_addr", {6'd0, mem_addr}, {6'd0, m_addr});
                if (m_wr) chk("R5 mem_wdata", {24'd0, mem_wdata}, {24'd0, m_wdata});
            end
            if (m_txv) chk("R6 tx_byte", {24'd0, tx_byte}, {24'd0, m_txb});
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [7:0] opener(input bit rd, input logic [25:0] a);
        return {1'b1, 1'b0, rd, a[25:21]};
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_addr(input logic [25:0] a);
        send({1'b0, a[20:14]});
        send({1'b0, a[13:7]});
        send({1'b0, a[6:0]});
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 100; i++) begin
            if (!mem_req && !tx_valid) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        wrap_up();
    end

    initial begin
        logic [25:0] wa;
        logic [25:0] ra;
        wa = 26'h2B4C3D1;
        ra = 26'h0123456;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held.
        chk("R1 mem_req in reset", {31'd0, mem_req}, 0);
        chk("R1 tx_valid in reset", {31'd0, tx_valid}, 0);
        chk("R1 cmd_addr in reset", {6'd0, cmd_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem_req after reset", {31'd0, mem_req}, 0);

        // R2, R3, R5: write frame, request visible right after the data byte.
        ack_delay = 3;
        send(opener(1'b0, wa));
        send_addr(wa);
        send(8'h5C);
        chk("R5 write request raised", {31'd0, mem_req}, 1);
        chk("R2 write type", {31'd0, mem_wr}, 1);
        chk("R3 write address", {6'd0, mem_addr}, {6'd0, wa});
        chk("R5 write data", {24'd0, mem_wdata}, 32'h5C);
        chk("R11 cmd_addr after write", {6'd0, cmd_addr}, {6'd0, wa});
        @(negedge clk);
        chk("R12 held before ack", {6'd0, mem_addr}, {6'd0, wa});
        wait_quiet();
        chk("R5 no reply after write", {31'd0, tx_valid}, 0);

        // R4, R6: read back with the transmitter stalled.
        rdy_mode = 2;
        send(opener(1'b1, wa));
        send_addr(wa);
        chk("R4 read request raised", {31'd0, mem_req}, 1);
        chk("R4 read type", {31'd0, mem_wr}, 0);
        for (int i = 0; i < 20 && !tx_valid; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R6 reply held while not ready", {31'd0, tx_valid}, 1);
        chk("R6 reply byte", {24'd0, tx_byte}, 32'h5C);
        // R10: a complete frame sent while the reply waits is ignored.
        send(opener(1'b1, ra));
        send_addr(ra);
        chk("R10 no request while busy", {31'd0, mem_req}, 0);
        chk("R10 cmd_addr kept while busy", {6'd0, cmd_addr}, {6'd0, wa});
        rdy_mode = 0;
        wait_quiet();
        chk("R10 nothing after busy frame", {31'd0, mem_req}, 0);

        // R7: a new opener mid-frame restarts it.
        send(opener(1'b0, wa));
        send({1'b0, wa[20:14]});
        send(opener(1'b1, ra));
        send_addr(ra);
        chk("R7 restarted frame issues read", {31'd0, mem_req}, 1);
        chk("R7 restarted address", {6'd0, mem_addr}, {6'd0, ra});
        wait_quiet();

        // R8: stray low bytes with no open frame.
        send(8'h12); send(8'h34); send(8'h56); send(8'h78);
        chk("R8 stray bytes ignored", {31'd0, mem_req}, 0);
        chk("R8 cmd_addr unchanged", {6'd0, cmd_addr}, {6'd0, ra});

        // R9: rejected opener aborts an open frame.
        send(opener(1'b1, wa));
        send({1'b0, wa[20:14]});
        send(8'hC3);
        send({1'b0, wa[13:7]});
        send({1'b0, wa[6:0]});
        send_addr(wa);
        chk("R9 rejected opener drops frame", {31'd0, mem_req}, 0);
        chk("R9 tx stays idle", {31'd0, tx_valid}, 0);

        // Mixed traffic, checked cycle by cycle against the model.
        rdy_mode = 1;
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            lfsr = step(lfsr);
            if (k % 500 == 0) ack_delay = int'(lfsr[2:0]);
            rx_valid = lfsr[5] | lfsr[9];
            case (lfsr[13:11])
                3'd0, 3'd1: rx_byte = {2'b10, lfsr[20:15]};
                3'd2:       rx_byte = {2'b11, lfsr[20:15]};
                default:    rx_byte = {1'b0, lfsr[22:16]};
            endcase
        end
        rx_valid = 1'b0;
        rdy_mode = 0;
        wait_quiet();
        wrap_up();
    end
endmodule